// File: doc/BRIEF.md
# Microcontroller Status Flag Register

This block holds the processor status byte of a small 8-bit microcontroller. Four arithmetic flags (carry, half carry, zero and signed overflow) are written by the ALU as part of each operation. Software can also write them as an ordinary register over the data bus. Two power-management flags record power-down entry and watchdog expiry. These two flags ignore every bus write and change only on a power-up reset, a watchdog-clear strobe, a halt strobe or a watchdog-timeout strobe.

All updates take effect at the rising clock edge. The read port is the packed byte taken straight from the registered state, so any change is visible on the cycle after the edge that captured it. The layout is bit 0 carry, bit 1 half carry, bit 2 zero, bit 3 overflow, bit 4 power-down and bit 5 timeout. Bits 7:6 read as zero.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low, all six flags clear, so `rd_data_o` reads 8'h00 after reset.
- R2: `rd_data_o[7:6]` is always 2'b00.
- R3: A bus write (`bus_wr_i`=1) loads `bus_wdata_i[3:0]` into the arithmetic flags at bit positions 0 to 3 (C, AC, Z, OV) for every bit whose ALU update enable is low.
- R4: A bus write has no effect on the power-down flag (bit 4) or the timeout flag (bit 5), whatever `bus_wdata_i[5:4]` holds.
- R5: For each bit i in 0 to 3, `alu_upd_i[i]`=1 loads `alu_flags_i[i]` into bit i. Bits whose enable is low and that are not bus-written keep their value.
- R6: When `alu_upd_i[i]` and `bus_wr_i` are both high in a cycle, bit i takes the ALU value.
- R7: `halt_i` sets the power-down flag and clears the timeout flag.
- R8: `wdt_clr_i` clears both the power-down flag and the timeout flag.
- R9: `wdt_tmo_i` sets the timeout flag, and it wins over `wdt_clr_i` or `halt_i` in the same cycle.
- R10: When `halt_i` and `wdt_clr_i` coincide, the power-down flag is set.
- R11: With no write, no ALU update and no strobe, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| alu_flags_i | input | 4 | ALU flag results, bit0 C, bit1 AC, bit2 Z, bit3 OV |
| alu_upd_i | input | 4 | Per-flag ALU update enables |
| bus_wr_i | input | 1 | Bus write strobe for the status byte |
| bus_wdata_i | input | 8 | Bus write data |
| wdt_clr_i | input | 1 | Watchdog-clear event strobe |
| halt_i | input | 1 | Halt event strobe |
| wdt_tmo_i | input | 1 | Watchdog-timeout event strobe |
| rd_data_o | output | 8 | Packed status byte |

## Verification
The collisions that matter are a bus write landing in the same cycle as an ALU flag update, and a timeout strobe landing with a clear or halt strobe. The bench sweeps all 16 enable masks against all 16 ALU flag values, each with and without a concurrent bus write whose data is the complement. It also sweeps every combination of the three event strobes, with and without a bus write, from each of the four starting power-flag states. Each cycle's expected byte is computed bit by bit from the stated priorities and compared one cycle after the edge.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
    localparam int ARITH_FLAGS = 4;
    localparam int STATUS_W    = 8;
    localparam int PDF_BIT     = ARITH_FLAGS;
    localparam int TO_BIT      = ARITH_FLAGS + 1;

    typedef struct packed {
        logic pdf;
        logic tmo;
    } pm_state_t;
endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alu_flags_i,
    input  logic [N-1:0] alu_upd_i,
    input  logic         bus_wr_i,
    input  logic [N-1:0] bus_wdata_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < N; i++) begin
            if (alu_upd_i[i]) begin
                flags_d[i] = alu_flags_i[i];
            end else if (bus_wr_i) begin
                flags_d[i] = bus_wdata_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/status_pm_flags.sv
module status_pm_flags
    import cpu_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wdt_clr_i,
    input  logic      halt_i,
    input  logic      wdt_tmo_i,
    output pm_state_t pm_o
);
    pm_state_t pm_d, pm_q;

    always_comb begin
        pm_d = pm_q;
        if (halt_i) begin
            pm_d.pdf = 1'b1;
        end else if (wdt_clr_i) begin
            pm_d.pdf = 1'b0;
        end
        if (wdt_tmo_i) begin
            pm_d.tmo = 1'b1;
        end else if (wdt_clr_i || halt_i) begin
            pm_d.tmo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q <= '0;
        end else begin
            pm_q <= pm_d;
        end
    end

    assign pm_o = pm_q;
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpu_status_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ARITH_FLAGS-1:0] alu_flags_i,
    input  logic [ARITH_FLAGS-1:0] alu_upd_i,
    input  logic                   bus_wr_i,
    input  logic [STATUS_W-1:0]    bus_wdata_i,
    input  logic                   wdt_clr_i,
    input  logic                   halt_i,
    input  logic                   wdt_tmo_i,
    output logic [STATUS_W-1:0]    rd_data_o
);
    logic [ARITH_FLAGS-1:0] arith_q;
    pm_state_t              pm_q;
    logic                   unused_wdata;

    // Upper write-data bits reach no storage: power flags are bus-immune.
    assign unused_wdata = ^bus_wdata_i[STATUS_W-1:ARITH_FLAGS];

    status_arith_flags #(.N(ARITH_FLAGS)) u_arith (
        .clk         (clk),
        .rst_n       (rst_n),
        .alu_flags_i (alu_flags_i),
        .alu_upd_i   (alu_upd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i[ARITH_FLAGS-1:0]),
        .flags_o     (arith_q)
    );

    status_pm_flags u_pm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_clr_i (wdt_clr_i),
        .halt_i    (halt_i),
        .wdt_tmo_i (wdt_tmo_i),
        .pm_o      (pm_q)
    );

    always_comb begin
        rd_data_o                = '0;
        rd_data_o[ARITH_FLAGS-1:0] = arith_q;
        rd_data_o[PDF_BIT]       = pm_q.pdf;
        rd_data_o[TO_BIT]        = pm_q.tmo;
    end
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] alu_flags_i,
    input logic [3:0] alu_upd_i,
    input logic       bus_wr_i,
    input logic       wdt_clr_i,
    input logic       halt_i,
    input logic       wdt_tmo_i,
    input logic [7:0] rd_data_o
);
    always @(negedge clk) begin
        if (rst_n) begin
            assert_top_zero_R2: assert (rd_data_o[7:6] == 2'b00);
        end
    end

    assert_bus_no_pm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !wdt_clr_i && !halt_i && !wdt_tmo_i) |=> $stable(rd_data_o[5:4]));

    assert_alu_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|alu_upd_i) |=> ((rd_data_o[3:0] & $past(alu_upd_i)) == ($past(alu_flags_i) & $past(alu_upd_i))));

    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !wdt_tmo_i) |=> (rd_data_o[5:4] == 2'b01));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_i && !halt_i && !wdt_tmo_i) |=> (rd_data_o[5:4] == 2'b00));

    assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo_i |=> rd_data_o[5]);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_i && alu_upd_i == 4'b0 && !wdt_clr_i && !halt_i && !wdt_tmo_i) |=> $stable(rd_data_o));
endmodule

bind cpu_status_reg cpu_status_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_flags_i (alu_flags_i),
    .alu_upd_i   (alu_upd_i),
    .bus_wr_i    (bus_wr_i),
    .wdt_clr_i   (wdt_clr_i),
    .halt_i      (halt_i),
    .wdt_tmo_i   (wdt_tmo_i),
    .rd_data_o   (rd_data_o)
);

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alu_flags_i = '0;
    logic [3:0] alu_upd_i = '0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic       wdt_clr_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       wdt_tmo_i = 1'b0;
    logic [7:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .alu_flags_i(alu_flags_i), .alu_upd_i(alu_upd_i),
        .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .wdt_clr_i(wdt_clr_i),
        .halt_i(halt_i), .wdt_tmo_i(wdt_tmo_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (rd_data_o !== exp) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data_o, exp);
        end
    endtask

    // Drive one cycle at a negedge, model the next byte, check at the next negedge.
    task automatic apply(input string tag, input logic [3:0] upd, input logic [3:0] fl,
                         input logic wr, input logic [7:0] wd,
                         input logic clr, input logic hlt, input logic tmo);
        logic [7:0] nx;
        alu_upd_i = upd; alu_flags_i = fl; bus_wr_i = wr; bus_wdata_i = wd;
        wdt_clr_i = clr; halt_i = hlt; wdt_tmo_i = tmo;
        nx = exp_q;
        for (int i = 0; i < 4; i++) begin
            if (upd[i]) nx[i] = fl[i];
            else if (wr) nx[i] = wd[i];
        end
        nx[4] = hlt ? 1'b1 : (clr ? 1'b0 : exp_q[4]);
        nx[5] = tmo ? 1'b1 : ((clr || hlt) ? 1'b0 : exp_q[5]);
        nx[7:6] = 2'b00;
        @(negedge clk);
        exp_q = nx;
        check(tag, exp_q);
        alu_upd_i = '0; bus_wr_i = 1'b0; wdt_clr_i = 1'b0; halt_i = 1'b0; wdt_tmo_i = 1'b0;
    endtask

    task automatic set_pm(input logic p, input logic t);
        apply("R8", 4'h0, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        if (p) apply("R7", 4'h0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        if (t) apply("R9", 4'h0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 8'h00);

        // Arithmetic flags: all enable masks x all ALU values, with and without bus write.
        for (int u = 0; u < 16; u++) begin
            for (int f = 0; f < 16; f++) begin
                for (int w = 0; w < 2; w++) begin
                    string tag;
                    tag = (w == 1) ? ((u != 0) ? "R6" : "R3") : "R5";
                    apply(tag, 4'(u), 4'(f), 1'(w), {4'hF, ~4'(f)}, 1'b0, 1'b0, 1'b0);
                end
            end
        end
        apply("R3", 4'h0, 4'h0, 1'b1, 8'hFA, 1'b0, 1'b0, 1'b0);
        apply("R11", 4'h0, 4'h5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

        // Power flags: every start state x every strobe combination, with and without bus write.
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 8; e++) begin
                for (int w = 0; w < 2; w++) begin
                    string tag;
                    if (e[2]) tag = "R9";
                    else if (e[1] && e[0]) tag = "R10";
                    else if (e[1]) tag = "R7";
                    else if (e[0]) tag = "R8";
                    else tag = "R4";
                    set_pm(s[0], s[1]);
                    apply(tag, 4'h0, 4'h0, 1'(w), (w == 1) ? 8'hF0 ^ 8'(s << 4) : 8'h00,
                          e[0], e[1], e[2]);
                end
            end
        end
        // R4: bus write with both power bits set in data, from cleared state.
        set_pm(1'b0, 1'b0);
        apply("R4", 4'h0, 4'h0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R2", {2'b00, exp_q[5:0]});

        // R1: reset from a fully set state.
        set_pm(1'b1, 1'b1);
        apply("R3", 4'h0, 4'h0, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        exp_q = 8'h00;
        @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h00);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: expected=done actual=hung");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule